// File: doc/BRIEF.md
# Time-Slice Hit Monitoring Snapshot Engine

This block keeps one saturating hit counter for each detector channel. A single-cycle time-slice start strobe marks each boundary. On the strobe, every counter is copied into its own snapshot register and restarts for the new slice, all in the same cycle. After the strobe the engine streams a monitoring packet on a 32-bit valid/ready output. The packet holds the snapshot words, followed by a fixed-length window of a dual-port memory that a host processor filled during the slice just ended.

The strobe also sends a one-cycle interrupt pulse to the processor and sets a busy flag. Busy stays set until the final packet word has been accepted, so the processor can poll it to learn when its memory window is free again. A strobe that arrives while a packet is still in flight does not start a second packet. It sets a sticky overrun flag, which the processor clears with a write-one-to-clear pulse. The memory port has a one-cycle read latency. The engine issues the next read while the current word is held by backpressure, so it sends one word per cycle when ready stays high.

Top module: `tsmon_engine`

## Requirements
- R1: After reset, out_valid_o, out_last_o, irq_o, busy_o, overrun_o and mem_rd_o are all 0, and every counter and snapshot is 0.
- R2: Each channel counts the cycles in which its hit input is 1. In a packet, word c (c = 0 to NUM_CH-1) carries the count of channel c for the slice just ended, zero-extended in bits [15:0].
- R3: A hit in the same cycle as the slice strobe counts toward the new slice, not toward the snapshot taken by that strobe.
- R4: A counter that reaches 65535 (all ones in 16 bits) stays at 65535 until the next strobe.
- R5: After the NUM_CH snapshot words, the packet carries MEM_WORDS memory words, read from addresses 0 up to MEM_WORDS-1 in ascending order. A packet has exactly NUM_CH+MEM_WORDS words (47 by default).
- R6: out_last_o is 1 only on the final memory word of a packet.
- R7: While out_valid_o is 1 and out_ready_i is 0, out_valid_o, out_data_o and out_last_o keep their values into the next cycle.
- R8: irq_o is 1 for exactly the cycle after each slice strobe, including a strobe that arrives while busy.
- R9: busy_o becomes 1 in the cycle after a strobe that arrives while idle. It returns to 0 in the cycle after the last word is accepted, and it is 1 whenever out_valid_o is 1.
- R10: A strobe while busy_o is 1 starts no new packet; the packet in flight still completes with all its words, and overrun_o becomes 1. overrun_o stays 1 until a cycle with overrun_clr_i = 1. A new overrun in that same cycle keeps the flag set.
- R11: With out_ready_i held at 1, the first word is valid 2 cycles after the strobe edge, and one word follows per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | NUM_CH | One hit pulse per channel per cycle |
| slice_start_i | input | 1 | Time-slice boundary strobe |
| overrun_clr_i | input | 1 | Write-one-to-clear for the overrun flag |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | MEM_AW | Memory word address within the monitoring window |
| mem_data_i | input | DATA_W | Memory read data, valid one cycle after mem_rd_o |
| out_valid_o | output | 1 | Packet word valid |
| out_ready_i | input | 1 | Downstream accepts the word |
| out_data_o | output | DATA_W | Packet word |
| out_last_o | output | 1 | Final word of the packet |
| irq_o | output | 1 | Interrupt pulse toward the processor |
| busy_o | output | 1 | Packet in progress; memory window not yet free |
| overrun_o | output | 1 | Sticky flag: strobe arrived while busy |

## Verification
The bench asserts a hit on every channel in the strobe cycle itself. A design that let those hits leak into the snapshot would report counts of 1 instead of 0. It also reports 0 instead of 1 in the following slice. Holding one channel high for more than 65535 cycles catches a counter that wraps to a small value. An irregular ready pattern combined with the one-cycle memory latency catches a sequencer that drops, repeats or reorders memory words, or changes held data under backpressure. A second strobe during a packet checks three things: the packet is neither restarted nor cut short, busy still drops at the end, and the overrun flag stays set until it is cleared.

// File: rtl/tsmon_pkg.sv
package tsmon_pkg;
   // flags travelling with the word held in the fetch stage
   typedef struct packed {
      logic valid;
      logic is_mem;
      logic fresh;
      logic last;
   } stage_flags_t;

   function automatic int unsigned width_of(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tsmon_hit_counter.sv
module tsmon_hit_counter #(
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_i,
   input  logic             capture_i,
   output logic [CNT_W-1:0] snap_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_max;

   generate
      if (SATURATE) begin : g_sat
         assign at_max = &cnt_q;
      end else begin : g_wrap
         assign at_max = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         snap_o <= '0;
      end else if (capture_i) begin
         snap_o <= cnt_q;
         cnt_q  <= hit_i ? CNT_W'(1) : '0;
      end else if (hit_i && !at_max) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/tsmon_counter_bank.sv
module tsmon_counter_bank #(
   parameter int unsigned NUM_CH   = 31,
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] hit_i,
   input  logic              capture_i,
   output logic [CNT_W-1:0]  snap_o [NUM_CH]
);
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         tsmon_hit_counter #(
            .CNT_W   (CNT_W),
            .SATURATE(SATURATE)
         ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit_i    (hit_i[c]),
            .capture_i(capture_i),
            .snap_o   (snap_o[c])
         );
      end
   endgenerate
endmodule

// File: rtl/tsmon_pkt_seq.sv
module tsmon_pkt_seq
   import tsmon_pkg::*;
#(
   parameter int unsigned NUM_CH    = 31,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned MEM_WORDS = 16,
   localparam int unsigned TOTAL    = NUM_CH + MEM_WORDS,
   localparam int unsigned IDX_W    = width_of(TOTAL + 1),
   localparam int unsigned CH_W     = width_of(NUM_CH),
   localparam int unsigned MEM_AW   = width_of(MEM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  snap_i [NUM_CH],
   output logic              mem_rd_o,
   output logic [MEM_AW-1:0] mem_addr_o,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic [DATA_W-1:0] out_data_o,
   output logic              out_last_o,
   output logic              busy_o
);
   logic [IDX_W-1:0]  fidx_q;
   logic              fetching_q;
   stage_flags_t      s1_q;
   logic [DATA_W-1:0] s1_data_q;
   logic [DATA_W-1:0] s1_word;
   logic [DATA_W-1:0] snap_word;
   logic [IDX_W-1:0]  mem_off;
   logic              out_free, move, issue, issue_mem, issue_last, done;

   assign out_free   = !out_valid_o || out_ready_i;
   assign move       = s1_q.valid && out_free;
   assign issue      = fetching_q && (!s1_q.valid || move);
   assign issue_mem  = (fidx_q >= IDX_W'(NUM_CH));
   assign issue_last = (fidx_q == IDX_W'(TOTAL - 1));
   assign done       = out_valid_o && out_ready_i && out_last_o;
   assign mem_off    = fidx_q - IDX_W'(NUM_CH);

   assign mem_rd_o   = issue && issue_mem;
   assign mem_addr_o = mem_off[MEM_AW-1:0];

   always_comb begin
      snap_word = '0;
      if (!issue_mem) snap_word[CNT_W-1:0] = snap_i[fidx_q[CH_W-1:0]];
   end

   // memory data is on the bus only in the cycle after the read
   assign s1_word = (s1_q.fresh && s1_q.is_mem) ? mem_data_i : s1_data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fidx_q     <= '0;
         fetching_q <= 1'b0;
         busy_o     <= 1'b0;
      end else begin
         if (start_i) begin
            fidx_q     <= '0;
            fetching_q <= 1'b1;
            busy_o     <= 1'b1;
         end else begin
            if (issue) begin
               fidx_q <= fidx_q + IDX_W'(1);
               if (issue_last) fetching_q <= 1'b0;
            end
            if (done) busy_o <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_q      <= '0;
         s1_data_q <= '0;
      end else if (issue) begin
         s1_q.valid  <= 1'b1;
         s1_q.is_mem <= issue_mem;
         s1_q.fresh  <= 1'b1;
         s1_q.last   <= issue_last;
         s1_data_q   <= snap_word;
      end else begin
         if (move) s1_q.valid <= 1'b0;
         s1_q.fresh <= 1'b0;
         if (s1_q.fresh && s1_q.is_mem) s1_data_q <= mem_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         out_data_o  <= '0;
         out_last_o  <= 1'b0;
      end else if (move) begin
         out_valid_o <= 1'b1;
         out_data_o  <= s1_word;
         out_last_o  <= s1_q.last;
      end else if (out_ready_i) begin
         out_valid_o <= 1'b0;
         out_last_o  <= 1'b0;
      end
   end
endmodule

// File: rtl/tsmon_engine.sv
module tsmon_engine
   import tsmon_pkg::*;
#(
   parameter int unsigned NUM_CH    = 31,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned MEM_WORDS = 16,
   parameter bit          SATURATE  = 1'b1,
   localparam int unsigned MEM_AW   = width_of(MEM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] hit_i,
   input  logic              slice_start_i,
   input  logic              overrun_clr_i,
   output logic              mem_rd_o,
   output logic [MEM_AW-1:0] mem_addr_o,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic [DATA_W-1:0] out_data_o,
   output logic              out_last_o,
   output logic              irq_o,
   output logic              busy_o,
   output logic              overrun_o
);
   generate
      if (NUM_CH < 1 || NUM_CH > 256) begin : g_bad_ch
         $error("tsmon_engine: NUM_CH out of range");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("tsmon_engine: CNT_W must fit in DATA_W");
      end
      if (MEM_WORDS < 1 || MEM_WORDS > 4096) begin : g_bad_mem
         $error("tsmon_engine: MEM_WORDS out of range");
      end
   endgenerate

   logic [CNT_W-1:0] snap [NUM_CH];
   logic             start;

   assign start = slice_start_i && !busy_o;

   tsmon_counter_bank #(
      .NUM_CH  (NUM_CH),
      .CNT_W   (CNT_W),
      .SATURATE(SATURATE)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit_i    (hit_i),
      .capture_i(slice_start_i),
      .snap_o   (snap)
   );

   tsmon_pkt_seq #(
      .NUM_CH   (NUM_CH),
      .CNT_W    (CNT_W),
      .DATA_W   (DATA_W),
      .MEM_WORDS(MEM_WORDS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .snap_i     (snap),
      .mem_rd_o   (mem_rd_o),
      .mem_addr_o (mem_addr_o),
      .mem_data_i (mem_data_i),
      .out_valid_o(out_valid_o),
      .out_ready_i(out_ready_i),
      .out_data_o (out_data_o),
      .out_last_o (out_last_o),
      .busy_o     (busy_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_o     <= 1'b0;
         overrun_o <= 1'b0;
      end else begin
         irq_o <= slice_start_i;
         if (slice_start_i && busy_o) overrun_o <= 1'b1;
         else if (overrun_clr_i)      overrun_o <= 1'b0;
      end
   end
endmodule

// File: rtl/tsmon_engine_chk.sv
module tsmon_engine_chk #(
   parameter int unsigned MEM_WORDS = 16,
   parameter int unsigned MEM_AW    = 4,
   parameter int unsigned DATA_W    = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              slice_start_i,
   input logic              overrun_clr_i,
   input logic              mem_rd_o,
   input logic [MEM_AW-1:0] mem_addr_o,
   input logic              out_valid_o,
   input logic              out_ready_i,
   input logic [DATA_W-1:0] out_data_o,
   input logic              out_last_o,
   input logic              irq_o,
   input logic              busy_o,
   input logic              overrun_o
);
   // R5
   mem_addr_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |-> (32'(mem_addr_o) < MEM_WORDS));
   // R6
   last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last_o |-> out_valid_o);
   // R7
   hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));
   // R8
   irq_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slice_start_i |=> irq_o);
   // R8
   irq_only_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(slice_start_i));
   // R9
   valid_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> busy_o);
   // R10
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_o && !overrun_clr_i) |=> overrun_o);
   // R10
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slice_start_i && busy_o) |=> overrun_o);
endmodule

bind tsmon_engine tsmon_engine_chk #(
   .MEM_WORDS(MEM_WORDS),
   .MEM_AW   (MEM_AW),
   .DATA_W   (DATA_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .slice_start_i(slice_start_i),
   .overrun_clr_i(overrun_clr_i),
   .mem_rd_o     (mem_rd_o),
   .mem_addr_o   (mem_addr_o),
   .out_valid_o  (out_valid_o),
   .out_ready_i  (out_ready_i),
   .out_data_o   (out_data_o),
   .out_last_o   (out_last_o),
   .irq_o        (irq_o),
   .busy_o       (busy_o),
   .overrun_o    (overrun_o)
);

// File: tb/tsmon_engine_bench.sv
module tsmon_engine_bench;
   localparam int NCH   = 31;
   localparam int NMEM  = 16;
   localparam int TOT   = NCH + NMEM;
   localparam int AW    = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NCH-1:0]  hit = '0;
   logic            strobe = 1'b0;
   logic            oclr = 1'b0;
   logic            mem_rd;
   logic [AW-1:0]   mem_addr;
   logic [31:0]     mem_q = '0;
   logic            ovalid, olast, irq, busy, overrun;
   logic            ready = 1'b0;
   logic [31:0]     odata;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int exp_snap [NCH];
   logic [31:0] pkt [TOT];
   int npkt, lastpos, iters;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   tsmon_engine u_tsmon_engine (
      .clk(clk), .rst_n(rst_n), .hit_i(hit), .slice_start_i(strobe),
      .overrun_clr_i(oclr), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
      .mem_data_i(mem_q), .out_valid_o(ovalid), .out_ready_i(ready),
      .out_data_o(odata), .out_last_o(olast), .irq_o(irq), .busy_o(busy),
      .overrun_o(overrun)
   );

   function automatic logic [31:0] mem_val(input int a);
      return 32'hC0DE_0000 | 32'(a * 3 + 7);
   endfunction

   always @(posedge clk) if (mem_rd) mem_q <= mem_val(int'(mem_addr));

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000) begin
         $display("FAIL watchdog expired: actual %0d cycles expected < 190000", cycles);
         errors = errors + 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // strobe with the given hit vector in the strobe cycle; checks irq and busy
   task automatic pulse_strobe(input logic [NCH-1:0] hv, input logic exp_busy);
      @(negedge clk);
      strobe = 1'b1;
      hit = hv;
      @(negedge clk);
      strobe = 1'b0;
      hit = '0;
      check("R8 irq after strobe", 32'(irq), 32'd1);
      check("R9 busy after strobe", 32'(busy), 32'(exp_busy));
   endtask

   // mode 0: ready high; mode 1: pseudo-random ready; inj>0 strobes at that iteration
   task automatic collect(input int mode, input int inj);
      logic        prev_stall = 1'b0;
      logic [31:0] prev_data = '0;
      logic        prev_last = 1'b0;
      npkt = 0; lastpos = -1; iters = 0;
      for (int it = 1; it < 600; it++) begin
         @(negedge clk);
         iters = it;
         strobe = (it == inj);
         if (it == 1) check("R8 irq single pulse", 32'(irq), 32'd0);
         if (inj > 0 && it == inj + 1) begin
            check("R10 overrun set", 32'(overrun), 32'd1);
            check("R8 irq on busy strobe", 32'(irq), 32'd1);
         end
         if (prev_stall) begin
            check("R7 valid held", 32'(ovalid), 32'd1);
            check("R7 data held", odata, prev_data);
            check("R7 last held", 32'(olast), 32'(prev_last));
         end
         if (mode == 0) ready = 1'b1;
         else begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ready = lfsr[0] | lfsr[3];
         end
         #1;
         prev_stall = ovalid && !ready;
         prev_data = odata;
         prev_last = olast;
         if (ovalid && ready) begin
            if (npkt < TOT) pkt[npkt] = odata;
            if (olast && lastpos < 0) lastpos = npkt;
            npkt++;
            if (olast) break;
         end
      end
      strobe = 1'b0;
      @(negedge clk);
      ready = 1'b0;
      check("R6 packet length", 32'(npkt), 32'(TOT));
      check("R6 last position", 32'(lastpos), 32'(TOT - 1));
      check("R9 busy falls", 32'(busy), 32'd0);
   endtask

   task automatic check_content(input string tag);
      for (int c = 0; c < NCH; c++)
         check({tag, " R2 snapshot word"}, pkt[c], 32'(exp_snap[c]));
      for (int m = 0; m < NMEM; m++)
         check("R5 memory word", pkt[NCH + m], mem_val(m));
   endtask

   task automatic t_reset;
      check("R1 valid", 32'(ovalid), 0);
      check("R1 last", 32'(olast), 0);
      check("R1 irq", 32'(irq), 0);
      check("R1 busy", 32'(busy), 0);
      check("R1 overrun", 32'(overrun), 0);
      check("R1 mem_rd", 32'(mem_rd), 0);
   endtask

   task automatic t_basic;
      for (int k = 0; k < NCH; k++) begin
         @(negedge clk);
         for (int c = 0; c < NCH; c++) hit[c] = (c >= k);
      end
      @(negedge clk);
      hit = '0;
      for (int c = 0; c < NCH; c++) exp_snap[c] = c + 1;
      pulse_strobe('0, 1'b1);
      collect(0, 0);
      check("R11 cycles to last word", 32'(iters), 32'(TOT + 1));
      check_content("basic");
   endtask

   task automatic t_strobe_hit;
      @(negedge clk); hit = '0; hit[1] = 1'b1;
      @(negedge clk);
      @(negedge clk); hit = '0;
      for (int c = 0; c < NCH; c++) exp_snap[c] = 0;
      exp_snap[1] = 2;
      pulse_strobe('1, 1'b1);
      collect(0, 0);
      check_content("R3 strobe-cycle hit excluded");
   endtask

   task automatic t_backpressure;
      for (int c = 0; c < NCH; c++) exp_snap[c] = 1;
      pulse_strobe('0, 1'b1);
      collect(1, 0);
      check_content("R3 strobe-cycle hit in new slice");
   endtask

   task automatic t_overrun;
      for (int c = 0; c < NCH; c++) exp_snap[c] = 0;
      pulse_strobe('0, 1'b1);
      collect(0, 6);
      check_content("R10 packet completes");
      idle(5);
      check("R10 no second packet", 32'(busy), 32'd0);
      check("R10 overrun sticky", 32'(overrun), 32'd1);
      @(negedge clk); oclr = 1'b1;
      @(negedge clk); oclr = 1'b0;
      check("R10 overrun cleared", 32'(overrun), 32'd0);
   endtask

   task automatic t_saturate;
      @(negedge clk); hit = '0; hit[5] = 1'b1; hit[6] = 1'b1;
      idle(100);
      hit[6] = 1'b0;
      idle(69900);
      hit = '0;
      for (int c = 0; c < NCH; c++) exp_snap[c] = 0;
      exp_snap[5] = 65535;
      exp_snap[6] = 100;
      pulse_strobe('0, 1'b1);
      collect(0, 0);
      check_content("R4 saturation");
   endtask

   initial begin
      idle(4);
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      t_basic();
      idle(3);
      t_strobe_hit();
      idle(3);
      t_backpressure();
      idle(3);
      t_overrun();
      idle(3);
      t_saturate();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule